// File: doc/BRIEF.md
# Serial-Loaded Nibble Control Register Bank

This block takes an asynchronous serial line (8 data bits, no parity, one stop bit) and turns each correctly framed byte into a write to a small bank of control registers. There are sixteen 4-bit registers, 64 bits in all, and their contents are driven out as one flat vector. Downstream logic uses these values as instrument settings such as a vertical offset, a trigger level and a gain selection. A setting wider than four bits spans several consecutive registers, and a host loads it one nibble per byte.

Every byte is a complete command by itself. The upper half of the byte selects the register and the lower half is the value stored there. There is no multi-byte framing, no readback and no acknowledgement. For each byte that is accepted, the block raises a one-clock write pulse, which can be stretched outside the block to drive an activity indicator.

The receiver runs from a 27 MHz clock at 115200 baud by default. It uses a 16x oversampling tick. It confirms the start bit at its midpoint and discards any frame whose stop bit reads low.

Top module: `serial_ctrl_regs`

## Requirements
- R1: After reset every register reads 0 on `reg_flat` and `wr_pulse` is low.
- R2: In an accepted byte, bits 7:4 select register k (0..15) and bits 3:0 are the value written. Register k is driven on `reg_flat[4k+3:4k]`.
- R3: A write is visible on `reg_flat` in the same clock cycle in which `wr_pulse` is high. That cycle is the clock edge after the receiver's internal byte strobe.
- R4: A write changes only the addressed register. All other registers keep their values.
- R5: A later write to the same register replaces the earlier value.
- R6: Line format: idle is high, the start bit is low, then 8 data bits are sent least significant bit first, then a high stop bit. A bit lasts 16*round(CLK_HZ/(16*BAUD)) clocks, which is 240 clocks at the defaults.
- R7: A frame whose stop bit is low is dropped. It causes no register write and no pulse.
- R8: A low pulse on an idle line that is shorter than half a bit is not taken as a start bit. It causes no write.
- R9: Frames sent back to back, with no idle time between them, are each accepted.
- R10: `wr_pulse` is high for exactly one clock per accepted byte and never for two consecutive clocks.
- R11: A 16-bit setting held in registers 8..11 (least significant nibble in register 8) is loaded by four bytes and then appears on `reg_flat[47:32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (27 MHz by default) |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial receive line, idle high |
| reg_flat | output | 64 | All sixteen registers, register k in bits 4k+3:4k |
| wr_pulse | output | 1 | One-clock pulse per accepted write |

## Verification
A bit-order or sampling-phase error in the receiver shows up on `reg_flat` one frame later, as a nibble in the wrong register or with the wrong value. A bad address decode either corrupts a register that was not addressed or leaves the addressed one stale, and this is visible in the write cycle itself. A false start or a missed framing error produces an extra `wr_pulse` or a spurious register change within one frame time of the stimulus. The bench therefore compares the whole 64-bit vector against its own model after every frame and counts write pulses.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // Clocks per oversampling tick, rounded to nearest.
  function automatic int unsigned os_divisor(input int unsigned clk_hz,
                                             input int unsigned baud,
                                             input int unsigned os_rate);
    return (clk_hz + (os_rate * baud) / 2) / (os_rate * baud);
  endfunction

  // Register selector taken from the upper part of a command byte.
  function automatic logic [3:0] cmd_addr(input logic [7:0] cmd);
    return cmd[7:4];
  endfunction

  // Value taken from the lower part of a command byte.
  function automatic logic [3:0] cmd_value(input logic [7:0] cmd);
    return cmd[3:0];
  endfunction

endpackage

// File: rtl/sctl_tick_gen.sv
module sctl_tick_gen #(
  parameter int unsigned DIV = 15
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sctl_uart_rx.sv
module sctl_uart_rx
  import sctl_pkg::*;
#(
  parameter int unsigned OS_RATE   = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_in,
  output logic                 byte_vld,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 frame_err
);
  localparam int unsigned OSW = $clog2(OS_RATE);
  localparam int unsigned BW  = $clog2(DATA_BITS + 1);
  localparam logic [OSW-1:0] MID  = OSW'(OS_RATE / 2 - 1);
  localparam logic [OSW-1:0] FULL = OSW'(OS_RATE - 1);
  localparam logic [BW-1:0]  NBITS = BW'(DATA_BITS);

  logic                 sync1_q, sync2_q, prev_q;
  rx_state_t            st_q;
  logic [OSW-1:0]       os_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] shift_q;

  wire fall_edge = prev_q & ~sync2_q;

  // Two-flop synchronizer plus edge history, all reset to idle level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= rx_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RX_IDLE;
      os_q      <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      frame_err <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          os_q <= '0;
          if (fall_edge) st_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (os_q == MID) begin
            os_q  <= '0;
            bit_q <= '0;
            st_q  <= sync2_q ? RX_IDLE : RX_DATA;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_q == FULL) begin
            os_q    <= '0;
            shift_q <= {sync2_q, shift_q[DATA_BITS-1:1]};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == NBITS - 1'b1) st_q <= RX_STOP;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_q == FULL) begin
            os_q <= '0;
            st_q <= RX_IDLE;
            if (sync2_q) begin
              byte_vld  <= 1'b1;
              byte_data <= shift_q;
            end else begin
              frame_err <= 1'b1;
            end
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sctl_reg_bank.sv
module sctl_reg_bank #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned REG_W = 4,
  localparam int unsigned ADDR_W = $clog2(NREGS),
  localparam int unsigned TOT_W  = NREGS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_value,
  output logic [NREGS-1:0]  we_vec,
  output logic [TOT_W-1:0]  flat,
  output logic              wr_pulse
);
  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    logic [REG_W-1:0] r_q;
    assign we_vec[k] = wr_en && (wr_addr == ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         r_q <= '0;
      else if (we_vec[k]) r_q <= wr_value;
    end
    assign flat[k*REG_W +: REG_W] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_pulse <= 1'b0;
    else        wr_pulse <= wr_en;
  end
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import sctl_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 27_000_000,
  parameter int unsigned BAUD    = 115_200,
  parameter int unsigned OS_RATE = 16,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned REG_W   = 4,
  localparam int unsigned ADDR_W = $clog2(NREGS),
  localparam int unsigned CMD_W  = ADDR_W + REG_W,
  localparam int unsigned TOT_W  = NREGS * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  output logic [TOT_W-1:0] reg_flat,
  output logic             wr_pulse
);
  localparam int unsigned TICK_DIV = os_divisor(CLK_HZ, BAUD, OS_RATE);

  // Named internal events, visible to the bound checker.
  logic             os_tick;
  logic             rx_byte_vld;
  logic [CMD_W-1:0] rx_byte;
  logic             rx_frame_err;
  logic [NREGS-1:0] bank_we;
  logic [3:0]       cmd_sel;
  logic [3:0]       cmd_val;

  assign cmd_sel = cmd_addr(8'(rx_byte));
  assign cmd_val = cmd_value(8'(rx_byte));

  sctl_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (os_tick)
  );

  sctl_uart_rx #(.OS_RATE(OS_RATE), .DATA_BITS(CMD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .rx_in    (rx_line),
    .byte_vld (rx_byte_vld),
    .byte_data(rx_byte),
    .frame_err(rx_frame_err)
  );

  sctl_reg_bank #(.NREGS(NREGS), .REG_W(REG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rx_byte_vld),
    .wr_addr (ADDR_W'(cmd_sel)),
    .wr_value(REG_W'(cmd_val)),
    .we_vec  (bank_we),
    .flat    (reg_flat),
    .wr_pulse(wr_pulse)
  );
endmodule

// File: rtl/sctl_chk.sv
module sctl_chk #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned REG_W = 4,
  localparam int unsigned ADDR_W = $clog2(NREGS),
  localparam int unsigned CMD_W  = ADDR_W + REG_W,
  localparam int unsigned TOT_W  = NREGS * REG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic [CMD_W-1:0] byte_data,
  input logic             frame_err,
  input logic [NREGS-1:0] bank_we,
  input logic [TOT_W-1:0] reg_flat,
  input logic             wr_pulse
);
  logic [ADDR_W-1:0] last_addr;
  logic [REG_W-1:0]  last_val;
  logic [TOT_W-1:0]  prev_flat;
  logic              last_vld;
  logic [TOT_W-1:0]  keep_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_val  <= '0;
      prev_flat <= '0;
      last_vld  <= 1'b0;
    end else begin
      last_addr <= byte_data[CMD_W-1 -: ADDR_W];
      last_val  <= byte_data[REG_W-1:0];
      prev_flat <= reg_flat;
      last_vld  <= byte_vld;
    end
  end

  always_comb begin
    keep_mask = '1;
    if (last_vld)
      keep_mask[int'(last_addr)*REG_W +: REG_W] = '0;
  end

  // R3
  pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> wr_pulse);

  // R10
  no_pulse_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !wr_pulse);

  // R10
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R2
  addressed_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> (reg_flat[int'(last_addr)*REG_W +: REG_W] == last_val));

  // R4
  others_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_flat ^ prev_flat) & keep_mask) == '0);

  // R7
  err_excludes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && byte_vld));

  // R2
  one_reg_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R7
  err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (!wr_pulse && $stable(reg_flat)));
endmodule

bind serial_ctrl_regs sctl_chk #(.NREGS(NREGS), .REG_W(REG_W)) u_sctl_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .byte_vld (rx_byte_vld),
  .byte_data(rx_byte),
  .frame_err(rx_frame_err),
  .bank_we  (bank_we),
  .reg_flat (reg_flat),
  .wr_pulse (wr_pulse)
);

// File: tb/test_serial_ctrl_regs.sv
`timescale 1ns/1ps
module test_serial_ctrl_regs;
  localparam real CLK_PERIOD = 37.0;
  localparam int CLK_HZ = 27_000_000;
  localparam int BAUD   = 115_200;
  localparam int BIT_CLKS = 16 * ((CLK_HZ + 8 * BAUD) / (16 * BAUD));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic [63:0] reg_flat;
  logic        wr_pulse;

  int compared = 0;
  int mismatched = 0;
  int pulses = 0;
  int accepted = 0;
  bit finished = 0;
  logic [3:0]  model [16];
  logic [63:0] snap_at_pulse = '0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  serial_ctrl_regs i_serial_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .reg_flat(reg_flat), .wr_pulse(wr_pulse)
  );

  always @(negedge clk) begin
    if (rst_n && wr_pulse) begin
      pulses++;
      snap_at_pulse = reg_flat;
    end
  end

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int k = 0; k < 16; k++) f[k*4 +: 4] = model[k];
    return f;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(logic [7:0] b, bit stop_val);
    rx_line = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_line = stop_val;
    repeat (BIT_CLKS) @(negedge clk);
    rx_line = 1'b1;
    if (stop_val) begin
      model[b[7:4]] = b[3:0];
      accepted++;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check64("R1 regs", reg_flat, 64'h0);
    check64("R1 pulse", {63'h0, wr_pulse}, 64'h0);
  endtask

  task automatic t_single_write();
    int p0 = pulses;
    send_frame(8'h3A, 1'b1); idle(60);
    check64("R2 single", reg_flat, model_flat());
    check64("R3 visible with pulse", {60'h0, snap_at_pulse[15:12]}, 64'hA);
    check64("R10 one pulse", 64'(pulses - p0), 64'd1);
  endtask

  task automatic t_other_untouched();
    send_frame(8'h75, 1'b1); idle(60);
    check64("R4 others kept", reg_flat, model_flat());
  endtask

  task automatic t_overwrite();
    send_frame(8'h31, 1'b1); idle(60);
    check64("R5 overwrite", {60'h0, reg_flat[15:12]}, 64'h1);
  endtask

  task automatic t_bit_order();
    send_frame(8'h81, 1'b1); idle(60);
    check64("R6 lsb first", {60'h0, reg_flat[35:32]}, 64'h1);
    send_frame(8'h18, 1'b1); idle(60);
    check64("R6 lsb first", reg_flat, model_flat());
  endtask

  task automatic t_all_regs();
    for (int k = 0; k < 16; k++) begin
      send_frame({4'(k), ~4'(k)}, 1'b1);
      idle(30);
    end
    check64("R2 all registers", reg_flat, model_flat());
  endtask

  task automatic t_word_setting();
    send_frame(8'h88, 1'b1); send_frame(8'h93, 1'b1);
    send_frame(8'hA0, 1'b1); send_frame(8'hBC, 1'b1);
    idle(60);
    check64("R11 16-bit word", {48'h0, reg_flat[47:32]}, 64'hC038);
  endtask

  task automatic t_bad_stop();
    int p0 = pulses;
    logic [3:0] keep = model[5];
    send_frame(8'h5F, 1'b0);
    model[5] = keep;
    idle(3 * BIT_CLKS);
    check64("R7 dropped frame", reg_flat, model_flat());
    check64("R7 no pulse", 64'(pulses - p0), 64'd0);
  endtask

  task automatic t_glitch();
    int p0 = pulses;
    rx_line = 1'b0; idle(BIT_CLKS / 6);
    rx_line = 1'b1; idle(12 * BIT_CLKS);
    check64("R8 glitch ignored", reg_flat, model_flat());
    check64("R8 no pulse", 64'(pulses - p0), 64'd0);
  endtask

  task automatic t_back_to_back();
    int p0 = pulses;
    send_frame(8'h02, 1'b1); send_frame(8'h17, 1'b1); send_frame(8'hF9, 1'b1);
    idle(60);
    check64("R9 back to back", reg_flat, model_flat());
    check64("R10 pulse per byte", 64'(pulses - p0), 64'd3);
  endtask

  task automatic finish_up();
    check64("R10 total pulses", 64'(pulses), 64'(accepted));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) model[k] = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(20);
    t_reset();
    t_single_write();
    t_other_untouched();
    t_overwrite();
    t_bit_order();
    t_all_regs();
    t_word_setting();
    t_bad_stop();
    t_glitch();
    t_back_to_back();
    finished = 1;
    finish_up();
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule